// File: doc/BRIEF.md
# Key-Gated Configuration Index Port

This block is the front end of a legacy I/O-space configuration space. A host reaches it through two byte ports: the index port at a base address and the data port one address above. To read or write a configuration register, the host first writes the register number to the index port. It then reads or writes the data port. The base is chosen by a strap pin, either 0x2E or 0x4E.

The configuration space is normally locked. The host opens it by writing the entry key 0x87 to the index port twice in a row, and closes it again with the exit key 0xAA. While the space is open, a logical-device number held in a select register decides which downstream device serves the banked window. The banked window is every index from 0x30 upward; accesses there are passed on through a simple read/write strobe interface. Indices below 0x30 are global. They hold the select register and the read-only vendor, device and revision identification bytes.

Host requests use a valid/ready handshake. A read to the data port is answered one cycle after it is accepted, on a response channel with its own valid/ready. `req_ready` is low only while a response is waiting and `rsp_ready` is low, so an unconsumed response stalls every new request.

Top module: `cfg_index_port`

## Requirements
- R1: After reset the space is locked (`cfg_open` = 0), the logical-device select reads 0, no response is pending and `req_ready` is 1.
- R2: The index port is at 0x2E when `strap_alt` = 0 and at 0x4E when it is 1, and the data port is at the index port address + 1. Requests to any other address are accepted but change nothing and produce no response.
- R3: The space opens only after two consecutive index-port writes of 0x87. An index-port write of any other value before the second 0x87 clears the match count, so 0x87, 0x55, 0x87 leaves the space locked.
- R4: While open, an index-port write of 0xAA locks the space again. Later data-port reads return 0xFF.
- R5: While locked, data-port reads return 0xFF. Data-port writes are ignored: the select register is unchanged and no downstream strobe fires.
- R6: While open, index 0x07 is the logical-device select register. It is written and read through the data port and its value drives the `ldn` output.
- R7: Indices 0x20/0x21 read the device ID high/low bytes, index 0x22 reads the revision, and indices 0x23/0x24 read the vendor ID 0x19/0x34. Writes to these indices are ignored. Other global indices below 0x30 read 0x00.
- R8: While open, a data-port write at an index of 0x30 or above pulses `dev_wr_en` for one cycle, with `dev_addr` equal to the index and `dev_wdata` equal to the written byte. A read there pulses `dev_rd_en` and returns `dev_rdata`. An index below 0x30 never raises a strobe, and the two strobes are never high together.
- R9: An accepted data-port read raises `rsp_valid` in the next cycle. `rsp_valid` and `rsp_data` stay stable until `rsp_ready` is high, and `req_ready` equals `!rsp_valid || rsp_ready`. Writes produce no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strap_alt | input | 1 | Base select: 0 gives 0x2E, 1 gives 0x4E |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Host request ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | I/O address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Read response ready |
| rsp_data | output | 8 | Read response byte |
| cfg_open | output | 1 | Configuration space open |
| ldn | output | 8 | Selected logical-device number |
| dev_rd_en | output | 1 | Downstream read strobe |
| dev_wr_en | output | 1 | Downstream write strobe |
| dev_addr | output | 8 | Downstream register index |
| dev_wdata | output | 8 | Downstream write byte |
| dev_rdata | input | 8 | Downstream read byte, same cycle as `dev_rd_en` |

## Verification
The in-line properties watch the following on every cycle:
- no downstream strobe fires and the select register stays still while locked;
- a strobe only ever carries a banked index, and the two strobes never overlap;
- opening is always preceded by an entry-key write, and an exit-key write closes the space in the next cycle;
- a stalled response holds both its valid and its data.

Only the directed scenarios can show the rest:
- the exact key ordering, including the broken 0x87, 0x55, 0x87 sequence;
- the identification values;
- read-back of the select register;
- the strap-chosen base and the silence of misaddressed requests.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;
  localparam logic [7:0] IDX_LDN    = 8'h07;
  localparam logic [7:0] IDX_DEV_HI = 8'h20;
  localparam logic [7:0] IDX_DEV_LO = 8'h21;
  localparam logic [7:0] IDX_REV    = 8'h22;
  localparam logic [7:0] IDX_VND_HI = 8'h23;
  localparam logic [7:0] IDX_VND_LO = 8'h24;
  localparam logic [7:0] LOCKED_READ = 8'hFF;

  typedef enum logic {KS_LOCKED, KS_OPEN} key_state_t;
endpackage

// File: rtl/cfg_key_fsm.sv
module cfg_key_fsm
  import cfg_port_pkg::*;
#(
  parameter logic [7:0] KEY_ENTER  = 8'h87,
  parameter logic [7:0] KEY_EXIT   = 8'hAA,
  parameter int         KEY_REPEAT = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idx_wr,
  input  logic [7:0] idx_wdata,
  output logic       open
);
  localparam int CW = $clog2(KEY_REPEAT + 1);
  localparam logic [CW-1:0] LAST = CW'(KEY_REPEAT - 1);

  key_state_t      state;
  logic [CW-1:0]   match_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= KS_LOCKED;
      match_cnt <= '0;
    end else if (idx_wr) begin
      if (state == KS_OPEN) begin
        if (idx_wdata == KEY_EXIT) begin
          state     <= KS_LOCKED;
          match_cnt <= '0;
        end
      end else if (idx_wdata == KEY_ENTER) begin
        if (match_cnt == LAST) begin
          state     <= KS_OPEN;
          match_cnt <= '0;
        end else begin
          match_cnt <= match_cnt + 1'b1;
        end
      end else begin
        match_cnt <= '0;
      end
    end
  end

  assign open = (state == KS_OPEN);

  AST_OPEN_NEEDS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(open) |-> $past(idx_wr && idx_wdata == KEY_ENTER)); // R3
  AST_EXIT_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (open && idx_wr && idx_wdata == KEY_EXIT) |=> !open); // R4
endmodule

// File: rtl/cfg_global_regs.sv
module cfg_global_regs
  import cfg_port_pkg::*;
#(
  parameter logic [15:0] DEV_ID    = 16'h0A53,
  parameter logic [7:0]  REV_ID    = 8'h12,
  parameter logic [15:0] VENDOR_ID = 16'h1934
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] idx,
  input  logic [7:0] wdata,
  output logic [7:0] ldn,
  output logic [7:0] rd_val
);
  always_ff @(posedge clk) begin
    if (!rst_n)                        ldn <= '0;
    else if (wr_en && idx == IDX_LDN)  ldn <= wdata;
  end

  always_comb begin
    case (idx)
      IDX_LDN:    rd_val = ldn;
      IDX_DEV_HI: rd_val = DEV_ID[15:8];
      IDX_DEV_LO: rd_val = DEV_ID[7:0];
      IDX_REV:    rd_val = REV_ID;
      IDX_VND_HI: rd_val = VENDOR_ID[15:8];
      IDX_VND_LO: rd_val = VENDOR_ID[7:0];
      default:    rd_val = 8'h00;
    endcase
  end
endmodule

// File: rtl/cfg_index_port.sv
module cfg_index_port
  import cfg_port_pkg::*;
#(
  parameter logic [15:0] BASE_PRI   = 16'h002E,
  parameter logic [15:0] BASE_ALT   = 16'h004E,
  parameter logic [7:0]  KEY_ENTER  = 8'h87,
  parameter logic [7:0]  KEY_EXIT   = 8'hAA,
  parameter int          KEY_REPEAT = 2,
  parameter logic [7:0]  FWD_BASE   = 8'h30,
  parameter logic [15:0] DEV_ID     = 16'h0A53,
  parameter logic [7:0]  REV_ID     = 8'h12,
  parameter logic [15:0] VENDOR_ID  = 16'h1934
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        strap_alt,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic [15:0] req_addr,
  input  logic [7:0]  req_wdata,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic [7:0]  rsp_data,
  output logic        cfg_open,
  output logic [7:0]  ldn,
  output logic        dev_rd_en,
  output logic        dev_wr_en,
  output logic [7:0]  dev_addr,
  output logic [7:0]  dev_wdata,
  input  logic [7:0]  dev_rdata
);
  logic [15:0] base;
  logic        acc, hit_idx, hit_dat, idx_wr, dat_wr, dat_rd, fwd;
  logic [7:0]  idx_q, glob_rd;

  assign base      = strap_alt ? BASE_ALT : BASE_PRI;
  assign req_ready = !rsp_valid || rsp_ready;
  assign acc       = req_valid && req_ready;
  assign hit_idx   = acc && (req_addr == base);
  assign hit_dat   = acc && (req_addr == base + 16'd1);
  assign idx_wr    = hit_idx && req_write;
  assign dat_wr    = hit_dat && req_write && cfg_open;
  assign dat_rd    = hit_dat && !req_write;
  assign fwd       = (idx_q >= FWD_BASE);

  cfg_key_fsm #(
    .KEY_ENTER(KEY_ENTER), .KEY_EXIT(KEY_EXIT), .KEY_REPEAT(KEY_REPEAT)
  ) u_key (
    .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .idx_wdata(req_wdata),
    .open(cfg_open)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)
      idx_q <= '0;
    else if (idx_wr && cfg_open && req_wdata != KEY_EXIT)
      idx_q <= req_wdata;
  end

  cfg_global_regs #(
    .DEV_ID(DEV_ID), .REV_ID(REV_ID), .VENDOR_ID(VENDOR_ID)
  ) u_glob (
    .clk(clk), .rst_n(rst_n), .wr_en(dat_wr && !fwd), .idx(idx_q),
    .wdata(req_wdata), .ldn(ldn), .rd_val(glob_rd)
  );

  assign dev_wr_en = dat_wr && fwd;
  assign dev_rd_en = dat_rd && cfg_open && fwd;
  assign dev_addr  = idx_q;
  assign dev_wdata = req_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (dat_rd) begin
      rsp_valid <= 1'b1;
      rsp_data  <= !cfg_open ? LOCKED_READ : (fwd ? dev_rdata : glob_rd);
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  AST_NO_STROBE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_open |-> !(dev_rd_en || dev_wr_en)); // R5
  AST_LDN_FROZEN_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_open |=> $stable(ldn)); // R5
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({dev_rd_en, dev_wr_en}) <= 1); // R8
  AST_FWD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_rd_en || dev_wr_en) |-> dev_addr >= FWD_BASE); // R8
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data))); // R9
endmodule

// File: tb/test_cfg_index_port.sv
module test_cfg_index_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strap_alt = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic req_ready, rsp_valid, cfg_open, dev_rd_en, dev_wr_en;
  logic [7:0] rsp_data, ldn, dev_addr, dev_wdata, dev_rdata;

  int n_chk = 0, n_fail = 0, cycles = 0;
  int wr_cnt = 0, rd_cnt = 0;
  logic [7:0] last_waddr = '0, last_wdata = '0;

  always #2 clk = ~clk;

  assign dev_rdata = dev_addr ^ 8'h5A;

  cfg_index_port i_cfg_index_port (
    .clk(clk), .rst_n(rst_n), .strap_alt(strap_alt),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .cfg_open(cfg_open), .ldn(ldn),
    .dev_rd_en(dev_rd_en), .dev_wr_en(dev_wr_en), .dev_addr(dev_addr),
    .dev_wdata(dev_wdata), .dev_rdata(dev_rdata)
  );

  always @(posedge clk) begin
    if (rst_n && dev_wr_en) begin
      wr_cnt <= wr_cnt + 1;
      last_waddr <= dev_addr;
      last_wdata <= dev_wdata;
    end
    if (rst_n && dev_rd_en) rd_cnt <= rd_cnt + 1;
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: act=hung exp=done");
      finish_run();
    end
  end

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic bus_read(logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check("R9 rsp_valid after read", rsp_valid, 1);
    d = rsp_data;
  endtask

  task automatic cfg_read(logic [7:0] idx, output logic [7:0] d);
    bus_write(16'h002E, idx);
    bus_read(16'h002F, d);
  endtask

  task automatic t_reset();
    check("R1 locked", cfg_open, 0);
    check("R1 ldn", ldn, 0);
    check("R1 rsp_valid", rsp_valid, 0);
    check("R1 req_ready", req_ready, 1);
  endtask

  task automatic t_locked();
    logic [7:0] d;
    int w0 = wr_cnt;
    bus_read(16'h002F, d);
    check("R5 locked read", d, 8'hFF);
    bus_write(16'h002F, 8'h06);
    @(negedge clk);
    check("R5 ldn untouched", ldn, 0);
    check("R5 no strobe", wr_cnt, w0);
  endtask

  task automatic t_unlock();
    bus_write(16'h002E, 8'h87);
    bus_write(16'h002E, 8'h55);
    bus_write(16'h002E, 8'h87);
    check("R3 broken key stays locked", cfg_open, 0);
    bus_write(16'h002E, 8'h87);
    check("R3 two keys open", cfg_open, 1);
  endtask

  task automatic t_ldn();
    logic [7:0] d;
    bus_write(16'h002E, 8'h07);
    bus_write(16'h002F, 8'h06);
    check("R6 ldn port", ldn, 8'h06);
    bus_read(16'h002F, d);
    check("R6 ldn readback", d, 8'h06);
  endtask

  task automatic t_ids();
    logic [7:0] d;
    cfg_read(8'h20, d); check("R7 dev hi", d, 8'h0A);
    cfg_read(8'h21, d); check("R7 dev lo", d, 8'h53);
    cfg_read(8'h22, d); check("R7 rev", d, 8'h12);
    cfg_read(8'h23, d); check("R7 vendor hi", d, 8'h19);
    cfg_read(8'h24, d); check("R7 vendor lo", d, 8'h34);
    bus_write(16'h002E, 8'h20);
    bus_write(16'h002F, 8'hFF);
    bus_read(16'h002F, d); check("R7 id write ignored", d, 8'h0A);
    cfg_read(8'h10, d); check("R7 other global", d, 8'h00);
  endtask

  task automatic t_forward();
    logic [7:0] d;
    int w0, r0;
    w0 = wr_cnt;
    bus_write(16'h002E, 8'h30);
    bus_write(16'h002F, 8'hC3);
    @(negedge clk);
    check("R8 wr strobe", wr_cnt, w0 + 1);
    check("R8 wr addr", last_waddr, 8'h30);
    check("R8 wr data", last_wdata, 8'hC3);
    r0 = rd_cnt;
    cfg_read(8'hF1, d);
    check("R8 rd data", d, 8'hF1 ^ 8'h5A);
    check("R8 rd strobe", rd_cnt, r0 + 1);
    w0 = wr_cnt;
    bus_write(16'h002E, 8'h2F);
    bus_write(16'h002F, 8'h11);
    @(negedge clk);
    check("R8 below window no strobe", wr_cnt, w0);
  endtask

  task automatic t_backpressure();
    bus_write(16'h002E, 8'h22);
    check("R9 no rsp on write", rsp_valid, 0);
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_write = 1'b0; req_addr = 16'h002F;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    check("R9 held valid", rsp_valid, 1);
    check("R9 req stalled", req_ready, 0);
    check("R9 held data", rsp_data, 8'h12);
    rsp_ready = 1'b1;
    @(negedge clk);
    check("R9 drained", rsp_valid, 0);
  endtask

  task automatic t_misdecode();
    bus_write(16'h004E, 8'hAA);
    check("R2 other address ignored", cfg_open, 1);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 16'h004F;
    @(negedge clk);
    req_valid = 1'b0;
    check("R2 no rsp off-base", rsp_valid, 0);
  endtask

  task automatic t_exit();
    logic [7:0] d;
    bus_write(16'h002E, 8'hAA);
    check("R4 exit locks", cfg_open, 0);
    bus_read(16'h002F, d);
    check("R4 locked read", d, 8'hFF);
  endtask

  task automatic t_alt_base();
    logic [7:0] d;
    @(negedge clk);
    strap_alt = 1'b1;
    bus_write(16'h002E, 8'h87);
    bus_write(16'h002E, 8'h87);
    check("R2 old base inert", cfg_open, 0);
    bus_write(16'h004E, 8'h87);
    bus_write(16'h004E, 8'h87);
    check("R2 alt base opens", cfg_open, 1);
    bus_write(16'h004E, 8'h24);
    bus_read(16'h004F, d);
    check("R2 alt data port", d, 8'h34);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_locked();
    t_unlock();
    t_ldn();
    t_ids();
    t_forward();
    t_backpressure();
    t_misdecode();
    t_exit();
    t_alt_base();
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule